// File: doc/BRIEF.md
# Local Level-1 Trigger Generator

This block produces local level-1 accept pulses, aligned to the bunch-crossing frame of the machine. A free-running bunch-crossing count and an orbit strobe come from outside. A 2-bit schedule code selects how triggers are spaced:

- locked to the orbit, at one fixed crossing;
- periodic in crossings;
- pseudo-random.

A single rate value N sets the spacing for all three schedules. A programmable window of crossings, the orbit gap, blanks all triggers.

Generation runs in two ways. A burst command produces a counted group of triggers. A continuous command keeps triggers flowing until a stop command arrives, and a status output reports while continuous generation is on. Two further commands ask the rest of the system to reset the event number and the orbit number. They are forwarded only while local trigger mode is selected.

Top module: `local_l1_gen`

## Requirements
- R1: After reset, `trig_out`, `cont_active`, `evn_rst_req` and `orn_rst_req` are all 0.
- R2: With `trig_type` = 2 (per crossing), triggers are issued every N+1 crossings, where N is `rate_n`.
- R3: With `trig_type` = 0 (per orbit), triggers are issued only at bunch count 500 (0x1F4), and every N+1 orbits.
- R4: With `trig_type` = 3 (random), a trigger is candidate in any crossing, with a probability of 1/(2(N+1)). The mean spacing is therefore about 2(N+1) crossings.
- R5: `trig_type` = 1 is reserved and never produces a trigger.
- R6: A one-cycle `cmd_burst`, given while no burst runs, produces exactly `burst_len`+1 triggers, so a `burst_len` of 0 gives one trigger.
- R7: A `cmd_burst` that arrives while a burst is still running is ignored. It neither restarts nor extends the burst.
- R8: No trigger is issued for a crossing whose count lies within `gap_begin`..`gap_end`, both limits included. When `gap_begin` > `gap_end`, nothing is blanked.
- R9: A blanked trigger counts toward neither the burst length nor the rate spacing. A trigger that falls due inside the gap is issued at the first crossing after the gap.
- R10: `cmd_cont_on` starts continuous generation and sets `cont_active`. `cmd_cont_off` stops it and clears `cont_active`, and it wins when both commands arrive together.
- R11: `cmd_evn_rst` and `cmd_orn_rst` produce a one-cycle pulse on `evn_rst_req` and `orn_rst_req` in the next cycle, but only while `local_mode` is 1.
- R12: `trig_out` is registered. It rises in the cycle after the crossing it was issued for.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bx_cnt | input | BX_W | Current bunch-crossing count |
| orbit_stb | input | 1 | One-cycle strobe at the start of each orbit |
| local_mode | input | 1 | Local trigger mode selected |
| trig_type | input | 2 | Schedule code: 0 per orbit, 1 reserved, 2 per crossing, 3 random |
| rate_n | input | RATE_W | Rate parameter N |
| burst_len | input | BURST_W | Burst length N (N+1 triggers) |
| gap_begin | input | BX_W | First blanked crossing |
| gap_end | input | BX_W | Last blanked crossing |
| cmd_burst | input | 1 | Start a burst |
| cmd_cont_on | input | 1 | Start continuous generation |
| cmd_cont_off | input | 1 | Stop continuous generation |
| cmd_evn_rst | input | 1 | Event-number reset command |
| cmd_orn_rst | input | 1 | Orbit-number reset command |
| trig_out | output | 1 | One-cycle trigger pulse |
| cont_active | output | 1 | Continuous generation on |
| evn_rst_req | output | 1 | Event-number reset request |
| orn_rst_req | output | 1 | Orbit-number reset request |

## Verification
The hardest case to reach from the ports is a trigger that falls due while the crossing count is inside the gap.

To create it, the bench programs a spacing shorter than the gap and lets continuous generation run across it. It then checks that the first trigger after the gap lands exactly on `gap_end`+1.

A second case polls the crossing count until it sits just before the gap and only then starts a burst. This way the burst straddles the gap, and the bench checks that its full count still arrives.

The bench also runs randomly drawn bursts of rate and length, and checks for each one the trigger count and every interval between triggers.

// File: rtl/local_l1_gen.sv
module local_l1_gen #(
  parameter int BX_W      = 12,
  parameter int RATE_W    = 16,
  parameter int BURST_W   = 16,
  parameter int FIRE_BX   = 500,
  parameter int RAND_W    = 16,
  parameter logic [31:0] LFSR_SEED = 32'hACE1_2468,
  parameter logic [31:0] LFSR_TAPS = 32'h8020_0003
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BX_W-1:0]    bx_cnt,
  input  logic               orbit_stb,
  input  logic               local_mode,
  input  logic [1:0]         trig_type,
  input  logic [RATE_W-1:0]  rate_n,
  input  logic [BURST_W-1:0] burst_len,
  input  logic [BX_W-1:0]    gap_begin,
  input  logic [BX_W-1:0]    gap_end,
  input  logic               cmd_burst,
  input  logic               cmd_cont_on,
  input  logic               cmd_cont_off,
  input  logic               cmd_evn_rst,
  input  logic               cmd_orn_rst,
  output logic               trig_out,
  output logic               cont_active,
  output logic               evn_rst_req,
  output logic               orn_rst_req
);

  localparam int SP_W   = RATE_W + 1;
  localparam int DIV_W  = RATE_W + 2;
  localparam int PROD_W = RAND_W + DIV_W;

  typedef enum logic [1:0] {
    K_ORBIT = 2'd0,
    K_RSVD  = 2'd1,
    K_BX    = 2'd2,
    K_RAND  = 2'd3
  } trig_kind_e;

  logic               burst_act;
  logic [BURST_W-1:0] burst_left;
  logic [SP_W-1:0]    sp_cnt;
  logic [31:0]        lfsr;
  logic               cand;

  wire active     = cont_active | burst_act;
  wire in_gap     = (bx_cnt >= gap_begin) && (bx_cnt <= gap_end);
  wire [SP_W-1:0] rate_ext = {1'b0, rate_n};
  wire due_bx     = sp_cnt >= rate_ext;
  wire due_orb    = sp_cnt > rate_ext;
  wire at_fire_bx = bx_cnt == BX_W'(FIRE_BX);
  wire sp_full    = &sp_cnt;

  wire [DIV_W-1:0]  rnd_div  = {1'b0, rate_n, 1'b0} + DIV_W'(2);
  wire [PROD_W-1:0] rnd_prod = PROD_W'(lfsr[RAND_W-1:0]) * PROD_W'(rnd_div);
  wire rnd_hit = rnd_prod < (PROD_W'(1) << RAND_W);

  always_comb begin
    case (trig_kind_e'(trig_type))
      K_ORBIT: cand = at_fire_bx && due_orb;
      K_BX:    cand = due_bx;
      K_RAND:  cand = rnd_hit;
      default: cand = 1'b0;
    endcase
  end

  wire fire  = active && cand && !in_gap;
  wire start = !active && (cmd_burst || (cmd_cont_on && !cmd_cont_off));
  wire sp_tick = (trig_type == K_BX) || ((trig_type == K_ORBIT) && orbit_stb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_cnt <= '1;
    end else if (start) begin
      sp_cnt <= '1;
    end else if (fire) begin
      sp_cnt <= '0;
    end else if (sp_tick && !sp_full) begin
      sp_cnt <= sp_cnt + SP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_act  <= 1'b0;
      burst_left <= '0;
    end else if (!burst_act && cmd_burst) begin
      burst_act  <= 1'b1;
      burst_left <= burst_len;
    end else if (burst_act && fire) begin
      if (burst_left == '0) burst_act <= 1'b0;
      else                  burst_left <= burst_left - BURST_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            cont_active <= 1'b0;
    else if (cmd_cont_off) cont_active <= 1'b0;
    else if (cmd_cont_on)  cont_active <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lfsr <= LFSR_SEED;
    else        lfsr <= {1'b0, lfsr[31:1]} ^ (lfsr[0] ? LFSR_TAPS : 32'd0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_out    <= 1'b0;
      evn_rst_req <= 1'b0;
      orn_rst_req <= 1'b0;
    end else begin
      trig_out    <= fire;
      evn_rst_req <= cmd_evn_rst & local_mode;
      orn_rst_req <= cmd_orn_rst & local_mode;
    end
  end

endmodule

// File: rtl/local_l1_gen_chk.sv
module local_l1_gen_chk #(
  parameter int BX_W    = 12,
  parameter int BURST_W = 16,
  parameter int FIRE_BX = 500
) (
  input logic               clk,
  input logic               rst_n,
  input logic [BX_W-1:0]    bx_cnt,
  input logic               local_mode,
  input logic [1:0]         trig_type,
  input logic [BX_W-1:0]    gap_begin,
  input logic [BX_W-1:0]    gap_end,
  input logic               cmd_burst,
  input logic               cmd_cont_on,
  input logic               cmd_cont_off,
  input logic               trig_out,
  input logic               cont_active,
  input logic               evn_rst_req,
  input logic               orn_rst_req,
  input logic               burst_act,
  input logic [BURST_W-1:0] burst_left
);

  assert_reserved_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_type == 2'd1) |=> !trig_out);

  assert_gap_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((bx_cnt >= gap_begin) && (bx_cnt <= gap_end)) |=> !trig_out);

  assert_orbit_crossing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_type == 2'd0) && (bx_cnt != BX_W'(FIRE_BX))) |=> !trig_out);

  assert_evn_local_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !local_mode |=> !evn_rst_req);

  assert_orn_local_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !local_mode |=> !orn_rst_req);

  assert_cont_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_cont_off |=> !cont_active);

  assert_cont_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cont_on && !cmd_cont_off) |=> cont_active);

  assert_idle_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cont_active && !burst_act) |=> !trig_out);

  assert_burst_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_act && cmd_burst) |=> (burst_left <= $past(burst_left)));

endmodule

bind local_l1_gen local_l1_gen_chk #(
  .BX_W(BX_W), .BURST_W(BURST_W), .FIRE_BX(FIRE_BX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bx_cnt(bx_cnt), .local_mode(local_mode),
  .trig_type(trig_type), .gap_begin(gap_begin), .gap_end(gap_end),
  .cmd_burst(cmd_burst), .cmd_cont_on(cmd_cont_on), .cmd_cont_off(cmd_cont_off),
  .trig_out(trig_out), .cont_active(cont_active),
  .evn_rst_req(evn_rst_req), .orn_rst_req(orn_rst_req),
  .burst_act(burst_act), .burst_left(burst_left)
);

// File: tb/sim_local_l1_gen.sv
module sim_local_l1_gen;
  localparam int CLK_T  = 10;
  localparam int ORBIT  = 3564;
  localparam int FIREBX = 500;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] bx = 12'd0;
  logic orbit_stb = 1'b0;
  logic local_mode = 1'b0;
  logic [1:0] trig_type = 2'd2;
  logic [15:0] rate_n = 16'd0;
  logic [15:0] burst_len = 16'd0;
  logic [11:0] gap_begin = 12'd1;
  logic [11:0] gap_end = 12'd0;
  logic cmd_burst = 1'b0, cmd_cont_on = 1'b0, cmd_cont_off = 1'b0;
  logic cmd_evn_rst = 1'b0, cmd_orn_rst = 1'b0;
  logic trig_out, cont_active, evn_rst_req, orn_rst_req;

  int tests = 0, fails = 0;
  int cyc = 0, ntrig = 0, last_t = 0, have_last = 0, exp_space = 0;
  int bad_space = 0, bad_bx = 0, in_gap_trigs = 0, chk_bx = 0, seen_bx = -1;
  int seen_hit = 0;

  local_l1_gen u0 (
    .clk(clk), .rst_n(rst_n), .bx_cnt(bx), .orbit_stb(orbit_stb),
    .local_mode(local_mode), .trig_type(trig_type), .rate_n(rate_n),
    .burst_len(burst_len), .gap_begin(gap_begin), .gap_end(gap_end),
    .cmd_burst(cmd_burst), .cmd_cont_on(cmd_cont_on), .cmd_cont_off(cmd_cont_off),
    .cmd_evn_rst(cmd_evn_rst), .cmd_orn_rst(cmd_orn_rst),
    .trig_out(trig_out), .cont_active(cont_active),
    .evn_rst_req(evn_rst_req), .orn_rst_req(orn_rst_req)
  );

  always #(CLK_T/2) clk = ~clk;

  // monitor and crossing-counter driver, all at the falling edge
  always @(negedge clk) begin
    if (trig_out) begin
      ntrig++;
      if (have_last != 0 && exp_space != 0 && (cyc - last_t) != exp_space) bad_space++;
      have_last = 1;
      last_t = cyc;
      if (chk_bx != 0 && int'(bx) != FIREBX) bad_bx++;
      if (bx >= gap_begin && bx <= gap_end) in_gap_trigs++;
      if (seen_bx >= 0 && int'(bx) == seen_bx) seen_hit = 1;
    end
    cyc++;
    bx = (int'(bx) == ORBIT - 1) ? 12'd0 : bx + 12'd1;
    orbit_stb = (bx == 12'd0);
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clear_mon(input int space);
    ntrig = 0; have_last = 0; exp_space = space;
    bad_space = 0; bad_bx = 0; in_gap_trigs = 0; seen_hit = 0;
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cont_on();
    cmd_cont_on = 1'b1; step(1); cmd_cont_on = 1'b0;
  endtask

  task automatic cont_off();
    cmd_cont_off = 1'b1; step(1); cmd_cont_off = 1'b0;
  endtask

  task automatic burst();
    cmd_burst = 1'b1; step(1); cmd_burst = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #(CLK_T * 190000);
    tests++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(2024);
    step(4);
    // R1 reset state
    check_eq("R1 trig_out", int'(trig_out), 0);
    check_eq("R1 cont_active", int'(cont_active), 0);
    check_eq("R1 reset reqs", int'(evn_rst_req | orn_rst_req), 0);
    rst_n = 1'b1;
    step(2);

    // R2/R10/R12 per-crossing continuous, N=3
    trig_type = 2'd2; rate_n = 16'd3;
    clear_mon(4);
    cont_on();
    check_eq("R10 cont_active set", int'(cont_active), 1);
    step(40);
    check_rng("R2 count N=3", ntrig, 9, 11);
    check_eq("R2 spacing N=3", bad_space, 0);
    cont_off();
    check_eq("R10 cont_active cleared", int'(cont_active), 0);
    step(3);
    clear_mon(0);
    step(50);
    check_eq("R10 stopped, no triggers", ntrig, 0);

    // R10 simultaneous on/off: off wins
    cmd_cont_on = 1'b1; cmd_cont_off = 1'b1; step(1);
    cmd_cont_on = 1'b0; cmd_cont_off = 1'b0;
    check_eq("R10 off wins", int'(cont_active), 0);

    // R6 burst of 5, spacing 3
    rate_n = 16'd2; burst_len = 16'd4;
    clear_mon(3);
    burst();
    step(100);
    check_eq("R6 burst count", ntrig, 5);
    check_eq("R6 burst spacing", bad_space, 0);

    // R6 burst_len 0 gives one
    burst_len = 16'd0;
    clear_mon(0);
    burst();
    step(50);
    check_eq("R6 single trigger", ntrig, 1);

    // R7 second burst command ignored while running
    rate_n = 16'd9; burst_len = 16'd3;
    clear_mon(10);
    burst();
    step(5);
    burst_len = 16'd20;
    burst();
    step(150);
    check_eq("R7 ignored re-burst count", ntrig, 4);
    check_eq("R7 spacing kept", bad_space, 0);
    burst_len = 16'd1;
    clear_mon(10);
    burst();
    step(60);
    check_eq("R7 burst accepted after end", ntrig, 2);

    // constrained random bursts, R2/R6
    for (int i = 0; i < 10; i++) begin
      int n, b;
      n = int'($urandom % 8);
      b = int'($urandom % 8);
      rate_n = 16'(n); burst_len = 16'(b);
      clear_mon(n + 1);
      burst();
      step(100);
      check_eq("R6 random burst count", ntrig, b + 1);
      check_eq("R2 random burst spacing", bad_space, 0);
    end

    // R8 gap blanking over a full orbit, N=0
    rate_n = 16'd0; gap_begin = 12'd1000; gap_end = 12'd1099;
    cont_on();
    step(10);
    clear_mon(0);
    step(ORBIT);
    check_eq("R8 orbit count with gap", ntrig, ORBIT - 100);
    check_eq("R8 none inside gap", in_gap_trigs, 0);
    cont_off();

    // R9 due trigger issued right after gap
    rate_n = 16'd4; gap_begin = 12'd2000; gap_end = 12'd2009;
    clear_mon(0);
    seen_bx = 2010;
    cont_on();
    step(ORBIT + 20);
    check_eq("R9 trigger at gap_end+1", seen_hit, 1);
    check_eq("R8 gap with N=4", in_gap_trigs, 0);
    seen_bx = -1;
    cont_off();

    // R9 burst straddling the gap keeps its full count
    rate_n = 16'd0; burst_len = 16'd9; gap_end = 12'd2049;
    while (bx != 12'd1995) step(1);
    clear_mon(0);
    burst();
    step(200);
    check_eq("R9 burst through gap count", ntrig, 10);
    check_eq("R9 burst none in gap", in_gap_trigs, 0);

    // R3 per orbit, N=0 then N=1
    gap_begin = 12'd1; gap_end = 12'd0;
    trig_type = 2'd0; rate_n = 16'd0;
    clear_mon(ORBIT);
    chk_bx = 1;
    cont_on();
    step(3 * ORBIT + 10);
    check_rng("R3 per-orbit count N=0", ntrig, 3, 4);
    check_eq("R3 spacing N=0", bad_space, 0);
    check_eq("R3 crossing 500", bad_bx, 0);
    cont_off();
    rate_n = 16'd1;
    clear_mon(2 * ORBIT);
    cont_on();
    step(4 * ORBIT + 10);
    check_rng("R3 per-orbit count N=1", ntrig, 2, 3);
    check_eq("R3 spacing N=1", bad_space, 0);
    check_eq("R3 crossing 500 N=1", bad_bx, 0);
    cont_off();
    chk_bx = 0;

    // R5 reserved code
    trig_type = 2'd1;
    clear_mon(0);
    cont_on();
    step(5000);
    check_eq("R5 reserved silent", ntrig, 0);
    cont_off();

    // R4 random rates
    trig_type = 2'd3; rate_n = 16'd7;
    clear_mon(0);
    cont_on();
    step(16000);
    check_rng("R4 random N=7", ntrig, 700, 1300);
    cont_off();
    rate_n = 16'd63;
    clear_mon(0);
    cont_on();
    step(16000);
    check_rng("R4 random N=63", ntrig, 80, 180);
    cont_off();

    // R11 reset requests
    local_mode = 1'b1;
    cmd_evn_rst = 1'b1; step(1); cmd_evn_rst = 1'b0;
    check_eq("R11 evn pulse", int'(evn_rst_req), 1);
    check_eq("R11 orn quiet", int'(orn_rst_req), 0);
    step(1);
    check_eq("R11 evn one cycle", int'(evn_rst_req), 0);
    cmd_orn_rst = 1'b1; step(1); cmd_orn_rst = 1'b0;
    check_eq("R11 orn pulse", int'(orn_rst_req), 1);
    step(1);
    check_eq("R11 orn one cycle", int'(orn_rst_req), 0);
    local_mode = 1'b0;
    cmd_evn_rst = 1'b1; cmd_orn_rst = 1'b1; step(1);
    cmd_evn_rst = 1'b0; cmd_orn_rst = 1'b0;
    check_eq("R11 evn blocked off-local", int'(evn_rst_req), 0);
    check_eq("R11 orn blocked off-local", int'(orn_rst_req), 0);

    summary();
    $finish;
  end
endmodule